// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block supervises a processor by watching the two lines of a two-wire serial bus. The processor keeps the watchdog satisfied by putting a complete bus transaction on the wire: a START condition and, later, a STOP condition. Each such pair clears the timeout count. If no pair arrives within the selected period, the block drives its active-low watchdog output low. The output stays low until a fresh START-then-STOP pair is seen.

The period is counted in ticks of an external one-cycle timebase strobe. A two-bit select picks one of three tick counts, or turns the watchdog off. The SDA and SCL inputs arrive already synchronised to the block clock. The block registers one copy of each line and judges every SDA transition against the SCL level held in that copy. Writing a new period select restarts the count.

Top module: `bus_watchdog`

## Requirements
- R1: After reset the watchdog output is high (inactive) and the tick count is zero.
- R2: A START is an SDA fall while the registered SCL copy is high. A STOP is an SDA rise while the registered SCL copy is high. SDA transitions while SCL is low are neither, and they do not restart the count.
- R3: The count restarts only when a START is followed, at any later time, by a STOP. A START without a following STOP does not restart it. A STOP with no pending START does not restart it.
- R4: With no restart, the output goes low on the clock edge that takes the Nth tick after the last restart. N is 1400 for select code 00, 600 for code 01 and 200 for code 10. After N-1 ticks the output is still high.
- R5: Once low, the output stays low through further ticks and through lone START conditions. The next START-then-STOP pair drives it high and clears the count, so a full N ticks are needed again.
- R6: Select code 11 disables the watchdog. The output is forced high on the next edge and the count is held at zero for as long as the code stays 11.
- R7: A change of the period select restarts the count from zero. It does not release an output that is already low.
- R8: Only clock edges with the tick strobe high advance the count. Any number of cycles without a tick never cause a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Serial data line, already synchronised |
| scl_i | input | 1 | Serial clock line, already synchronised |
| tick_i | input | 1 | One-cycle timebase strobe |
| period_sel_i | input | 2 | Timeout select: 00=1400, 01=600, 10=200 ticks, 11=off |
| wdo_n_o | output | 1 | Watchdog output, low when the period has run out |

## Verification
The assertions assume that SDA and SCL are already synchronous to the block clock. They also assume that the period select is a level that changes no more than once per cycle. The monotonic-count property assumes that the tick strobe is the only thing advancing the count. The bench drives every input at the falling clock edge and steps the bus lines one cycle at a time, so each START and STOP lands on a known rising edge. It holds the tick strobe low during bus sequences and during select changes, so a restart never coincides with a count step.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

   typedef enum logic [1:0] {
      PSEL_LONG  = 2'b00,
      PSEL_MID   = 2'b01,
      PSEL_SHORT = 2'b10,
      PSEL_OFF   = 2'b11
   } psel_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/bwd_cond_detect.sv
module bwd_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_i,
   input  logic scl_i,
   output logic kick_o
);
   logic sda_q, scl_q;
   logic start_evt, stop_evt;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_q <= 1'b1;
         scl_q <= 1'b1;
      end else begin
         sda_q <= sda_i;
         scl_q <= scl_i;
      end
   end

   // transitions on SDA qualified by the held SCL level
   assign start_evt = scl_q &  sda_q & ~sda_i;
   assign stop_evt  = scl_q & ~sda_q &  sda_i;

   // a START arms; a STOP while armed completes the pair
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           armed_q <= 1'b0;
      else if (start_evt)   armed_q <= 1'b1;
      else if (stop_evt)    armed_q <= 1'b0;
   end

   assign kick_o = stop_evt & armed_q;

endmodule

// File: rtl/bwd_period_lut.sv
module bwd_period_lut #(
   parameter int unsigned LIM_LONG  = 1400,
   parameter int unsigned LIM_MID   = 600,
   parameter int unsigned LIM_SHORT = 200,
   parameter int unsigned CNT_W     = 11,
   parameter bit          LIMIT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       sel_i,
   output logic [CNT_W-1:0] last_o,
   output logic             off_o
);
   import bwd_pkg::*;

   logic [CNT_W-1:0] last_c;
   logic             off_c;

   always_comb begin
      off_c  = 1'b0;
      last_c = CNT_W'(LIM_LONG - 1);
      unique case (psel_e'(sel_i))
         PSEL_LONG:  last_c = CNT_W'(LIM_LONG - 1);
         PSEL_MID:   last_c = CNT_W'(LIM_MID - 1);
         PSEL_SHORT: last_c = CNT_W'(LIM_SHORT - 1);
         PSEL_OFF:   off_c  = 1'b1;
         default:    off_c  = 1'b1;
      endcase
   end

   generate
      if (LIMIT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_o <= CNT_W'(LIM_LONG - 1);
               off_o  <= 1'b0;
            end else begin
               last_o <= last_c;
               off_o  <= off_c;
            end
         end
      end else begin : g_comb
         assign last_o = last_c;
         assign off_o  = off_c;
      end
   endgenerate

endmodule

// File: rtl/bwd_counter.sv
module bwd_counter #(
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             kick_i,
   input  logic [1:0]       sel_i,
   input  logic [CNT_W-1:0] last_i,
   input  logic             off_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [1:0]       sel_q_o,
   output logic             expired_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [1:0]       sel_q;
   logic             exp_q;
   logic             sel_chg;

   assign sel_chg = (sel_i != sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 2'b00;
      else        sel_q <= sel_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (off_i || kick_i) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (sel_chg) begin
         cnt_q <= '0;
      end else if (tick_i && !exp_q) begin
         if (cnt_q >= last_i) exp_q <= 1'b1;
         else                 cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o     = cnt_q;
   assign sel_q_o   = sel_q;
   assign expired_o = exp_q;

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
   parameter int unsigned LIM_LONG  = 1400,
   parameter int unsigned LIM_MID   = 600,
   parameter int unsigned LIM_SHORT = 200,
   parameter bit          LIMIT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_i,
   input  logic       scl_i,
   input  logic       tick_i,
   input  logic [1:0] period_sel_i,
   output logic       wdo_n_o
);
   localparam int unsigned LIM_MAX = bwd_pkg::max3(LIM_LONG, LIM_MID, LIM_SHORT);
   localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);

   generate
      if (LIM_LONG < 2 || LIM_MID < 2 || LIM_SHORT < 2) begin : g_bad_limit
         $error("bus_watchdog: every period must be at least two ticks");
      end
      if (LIMIT_REG && (LIM_SHORT < 3)) begin : g_bad_reg
         $error("bus_watchdog: registered limit needs periods of three ticks or more");
      end
   endgenerate

   logic             kick;
   logic [CNT_W-1:0] limit;
   logic             off;
   logic [CNT_W-1:0] cnt;
   logic [1:0]       sel_q;
   logic             expired;

   bwd_cond_detect u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .sda_i  (sda_i),
      .scl_i  (scl_i),
      .kick_o (kick)
   );

   bwd_period_lut #(
      .LIM_LONG  (LIM_LONG),
      .LIM_MID   (LIM_MID),
      .LIM_SHORT (LIM_SHORT),
      .CNT_W     (CNT_W),
      .LIMIT_REG (LIMIT_REG)
   ) u_lut (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (period_sel_i),
      .last_o (limit),
      .off_o  (off)
   );

   bwd_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .kick_i    (kick),
      .sel_i     (period_sel_i),
      .last_i    (limit),
      .off_i     (off),
      .cnt_o     (cnt),
      .sel_q_o   (sel_q),
      .expired_o (expired)
   );

   assign wdo_n_o = ~expired;

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
   parameter int unsigned CNT_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic [1:0]       period_sel_i,
   input logic             wdo_n_o,
   input logic             kick,
   input logic [1:0]       sel_q,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] limit
);
   p_off_forces_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (period_sel_i == 2'b11) |=> wdo_n_o)
      else $error("R6: output low while watchdog disabled");

   p_fall_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdo_n_o) |-> $past(tick_i))
      else $error("R8: output fell without a tick");

   p_rise_needs_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdo_n_o) |-> ($past(kick) || $past(period_sel_i) == 2'b11))
      else $error("R5: output released without a START-STOP pair");

   p_count_monotonic_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!kick && period_sel_i == sel_q && period_sel_i != 2'b11) |=> (cnt >= $past(cnt)))
      else $error("R3: count went back without a restart");

   p_count_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (period_sel_i != 2'b11 && period_sel_i == sel_q) |-> (cnt <= limit))
      else $error("R4: count beyond the selected period");

   p_change_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (period_sel_i != sel_q) |=> (cnt == '0))
      else $error("R7: select change did not restart the count");

endmodule

bind bus_watchdog bwd_checker #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_i       (tick_i),
   .period_sel_i (period_sel_i),
   .wdo_n_o      (wdo_n_o),
   .kick         (kick),
   .sel_q        (sel_q),
   .cnt          (cnt),
   .limit        (limit)
);

// File: tb/bus_watchdog_bench.sv
module bus_watchdog_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sda = 1'b1;
   logic       scl = 1'b1;
   logic       tick = 1'b0;
   logic [1:0] sel = 2'b00;
   logic       wdo_n;
   int         checks = 0;
   int         fails = 0;

   always #10 clk = ~clk;

   bus_watchdog u_bus_watchdog (
      .clk          (clk),
      .rst_n        (rst_n),
      .sda_i        (sda),
      .scl_i        (scl),
      .tick_i       (tick),
      .period_sel_i (sel),
      .wdo_n_o      (wdo_n)
   );

   task automatic check(input string req, input logic exp);
      checks++;
      if (wdo_n !== exp) begin
         fails++;
         $display("FAIL %s: wdo_n=%b expected %b at %0t", req, wdo_n, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
      end
      tick = 1'b0;
   endtask

   task automatic bus_start;
      sda = 1'b1; cyc(1);
      scl = 1'b1; cyc(1);
      sda = 1'b0; cyc(1);
      scl = 1'b0; cyc(1);
   endtask

   task automatic bus_stop;
      sda = 1'b0; cyc(1);
      scl = 1'b1; cyc(1);
      sda = 1'b1; cyc(1);
   endtask

   task automatic lone_stop;
      scl = 1'b0; cyc(1);
      sda = 1'b0; cyc(1);
      scl = 1'b1; cyc(1);
      sda = 1'b1; cyc(1);
   endtask

   task automatic kick_pair;
      bus_start();
      bus_stop();
   endtask

   task automatic set_sel(input logic [1:0] v);
      sel = v;
      cyc(2);
   endtask

   task automatic t_reset;
      check("R1 reset output high", 1'b1);
      cyc(50);
      check("R8 idle cycles without tick", 1'b1);
   endtask

   task automatic t_expire(input logic [1:0] code, input int n, input string req);
      kick_pair();
      set_sel(code);
      ticks(n - 1);
      check(req, 1'b1);
      ticks(1);
      check(req, 1'b0);
   endtask

   task automatic t_sticky;
      ticks(300);
      check("R5 stays low after more ticks", 1'b0);
      bus_start();
      check("R5 lone START keeps output low", 1'b0);
      bus_stop();
      check("R5 pair releases output", 1'b1);
      ticks(199);
      check("R5 count cleared by pair", 1'b1);
      ticks(1);
      check("R5 full period after release", 1'b0);
   endtask

   task automatic t_start_alone;
      kick_pair();
      ticks(150);
      bus_start();
      ticks(50);
      check("R3 START alone no restart", 1'b0);
      bus_stop();
      check("R3 later STOP completes pair", 1'b1);
   endtask

   task automatic t_stop_alone;
      kick_pair();
      ticks(150);
      lone_stop();
      ticks(50);
      check("R3 STOP alone no restart", 1'b0);
      kick_pair();
      check("R3 pair after lone STOP", 1'b1);
   endtask

   task automatic t_scl_low;
      kick_pair();
      ticks(150);
      scl = 1'b0; cyc(1);
      sda = 1'b0; cyc(1);
      sda = 1'b1; cyc(1);
      sda = 1'b0; cyc(1);
      sda = 1'b1; cyc(1);
      scl = 1'b1; cyc(1);
      ticks(50);
      check("R2 SDA edges with SCL low ignored", 1'b0);
      kick_pair();
      check("R2 proper pair detected", 1'b1);
   endtask

   task automatic t_change;
      set_sel(2'b10);
      kick_pair();
      ticks(150);
      set_sel(2'b01);
      ticks(599);
      check("R7 select change restarts count", 1'b1);
      ticks(1);
      check("R7 new period expires", 1'b0);
      set_sel(2'b10);
      check("R7 change keeps output low", 1'b0);
   endtask

   task automatic t_off;
      set_sel(2'b11);
      check("R6 disable releases output", 1'b1);
      ticks(2000);
      check("R6 no timeout while disabled", 1'b1);
      set_sel(2'b10);
      ticks(199);
      check("R6 count held at zero", 1'b1);
      ticks(1);
      check("R6 re-enabled expires", 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_expire(2'b10, 200, "R4 code 10 period 200");
      t_sticky();
      t_start_alone();
      t_stop_alone();
      t_scl_low();
      t_expire(2'b01, 600, "R4 code 01 period 600");
      t_expire(2'b00, 1400, "R4 code 00 period 1400");
      kick_pair();
      t_change();
      t_off();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule